// File: doc/BRIEF.md
# Holdover Frequency Slew Limiter

This block sits between the frequency-offset source of two clock generators and the synthesizers they drive. Each channel takes a signed target frequency offset and, while the generator is steadily locked or steadily free-running, simply passes it on. When the generator moves between the synchronized and the holdover condition, the control logic raises a transfer strobe. The channel then walks its output offset toward the target at a bounded rate instead of letting it jump. The rate bound is chosen per channel from three ppm-per-second ceilings, or slew limiting can be switched off.

Offsets are signed words whose least significant bit is 1/1024 ppm. Internally each channel keeps 16 further fractional bits. Stepping happens only on a shared control tick that recurs every 1 ms, so one tick moves the offset by the ceiling divided by 1000. Each channel runs a two-state machine. TRACK passes the target through. RAMP slews toward the target. TRACK moves to RAMP on an accepted strobe that carries a non-zero rate. RAMP returns to TRACK when a tick lands the offset on the target, or when an accepted strobe carries the unlimited rate. An accepted strobe during RAMP retargets the ramp and stays in RAMP.

Top module: `freq_slew_pair`

## Requirements
- R1: During and straight after reset, every channel outputs offset 0 with the ramping flag low, and its recorded mode is 0 (synchronized).
- R2: While a channel is not ramping, its output equals the target offset sampled at the previous clock edge, so there is one cycle of latency.
- R3: While ramping, the output changes only on clock edges where the tick was high. On each such edge the internal offset moves toward the target by exactly one step.
- R4: Rate select 00 means unlimited, 01 means 1 ppm/s, 10 means 1.5 ppm/s and 11 means 2 ppm/s. For k half-ppm per second (k = 2, 3, 4), the step in units of 2^-16 LSB is (k*512*65536 + 500)/1000 with integer division, which gives 67109, 100663 and 134218. The output is the internal offset shifted right arithmetically by 16.
- R5: When the remaining distance on a tick is not more than one step, the output lands exactly on the target and the ramping flag drops after that edge.
- R6: An accepted strobe takes no step in its own cycle. A ramp begins or is retargeted from the current internal offset, so the output does not jump when the ramp starts or when it is retargeted.
- R7: A strobe is accepted only when the mode input differs from the mode recorded at the last accepted strobe. Any other strobe is ignored, and the output keeps following the target.
- R8: The rate select is captured at an accepted strobe. Changing the rate select during a ramp has no effect until the next accepted strobe.
- R9: An accepted strobe with rate 00 starts no ramp. If a ramp is running, such a strobe ends it, and the output follows the target from the next cycle.
- R10: The two channels are independent. The strobe, mode, rate and target of one channel never change the output or flag of the other.
- R11: While ramping, a step never moves the output away from the target it was stepping toward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse at each 1 ms control interval, shared by both channels |
| mode_i | input | NCH | Per channel: 0 = synchronized, 1 = holdover |
| xfer_stb_i | input | NCH | Per channel: one-cycle strobe marking a state transfer |
| rate_sel_i | input | NCH x 2 | Per channel slew ceiling select (encoding in R4) |
| tgt_i | input | NCH x W | Per channel signed target offset, 1/1024 ppm per LSB |
| out_o | output | NCH x W | Per channel signed slewed offset |
| ramping_o | output | NCH | Per channel: high while in RAMP |

## Verification
The properties assume that the target stays within the signed W-bit range. They also assume that the tick and the strobes are single-cycle pulses sampled on the rising edge. The monotonic and step-bound properties rely on the target being stable across a tick edge. The stimulus always changes targets, modes, rates, strobes and ticks half a period away from the active edge. Each one-cycle tick is followed by an idle cycle, and the target is held constant for the whole ramp whose progress is being measured. Retargets are issued only between ticks, so each step is taken against a single known target.

// File: rtl/slew_pkg.sv
package slew_pkg;

    typedef enum logic {
        ST_TRACK = 1'b0,
        ST_RAMP  = 1'b1
    } slew_state_e;

    typedef enum logic [1:0] {
        RATE_OFF = 2'b00,
        RATE_1P0 = 2'b01,
        RATE_1P5 = 2'b10,
        RATE_2P0 = 2'b11
    } rate_sel_e;

    // Step per tick, in 2^-frac LSB, for a ceiling of half_ppm/2 ppm per second.
    function automatic longint step_units(input int half_ppm, input int lsb_per_ppm,
                                          input int frac, input int ticks_per_s);
        longint num;
        num = (longint'(half_ppm) * longint'(lsb_per_ppm)) <<< frac;
        return (num / 2 + longint'(ticks_per_s / 2)) / longint'(ticks_per_s);
    endfunction

endpackage

// File: rtl/slew_step_lut.sv
module slew_step_lut
    import slew_pkg::*;
#(
    parameter int AW          = 40,
    parameter int FRAC        = 16,
    parameter int LSB_PER_PPM = 1024,
    parameter int TICKS_PER_S = 1000
) (
    input  rate_sel_e         rate_i,
    output logic [AW-1:0]     step_o
);

    localparam longint STEP_1P0 = step_units(2, LSB_PER_PPM, FRAC, TICKS_PER_S);
    localparam longint STEP_1P5 = step_units(3, LSB_PER_PPM, FRAC, TICKS_PER_S);
    localparam longint STEP_2P0 = step_units(4, LSB_PER_PPM, FRAC, TICKS_PER_S);

    always_comb begin
        unique case (rate_i)
            RATE_OFF: step_o = '0;
            RATE_1P0: step_o = AW'(STEP_1P0);
            RATE_1P5: step_o = AW'(STEP_1P5);
            RATE_2P0: step_o = AW'(STEP_2P0);
        endcase
    end

endmodule

// File: rtl/slew_stepper.sv
module slew_stepper #(
    parameter int AW = 40
) (
    input  logic signed [AW-1:0] acc_i,
    input  logic signed [AW-1:0] tgt_i,
    input  logic        [AW-1:0] step_i,
    output logic signed [AW-1:0] acc_o,
    output logic                 land_o
);

    logic signed [AW:0] diff;
    logic        [AW:0] mag;

    always_comb begin
        diff   = {tgt_i[AW-1], tgt_i} - {acc_i[AW-1], acc_i};
        mag    = diff[AW] ? (~diff + 1'b1) : diff;
        land_o = (mag <= {1'b0, step_i});
        if (land_o) begin
            acc_o = tgt_i;
        end else if (diff[AW]) begin
            acc_o = acc_i - $signed(step_i);
        end else begin
            acc_o = acc_i + $signed(step_i);
        end
    end

endmodule

// File: rtl/slew_channel.sv
module slew_channel
    import slew_pkg::*;
#(
    parameter int W           = 24,
    parameter int FRAC        = 16,
    parameter int LSB_PER_PPM = 1024,
    parameter int TICKS_PER_S = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         mode_i,
    input  logic         stb_i,
    input  logic [1:0]   rate_sel_i,
    input  logic [W-1:0] tgt_i,
    output logic [W-1:0] out_o,
    output logic         ramping_o
);

    localparam int AW = W + FRAC;

    slew_state_e        state_q, state_d;
    rate_sel_e          rate_q, rate_d;
    logic               mode_seen_q, mode_seen_d;
    logic signed [AW-1:0] acc_q, acc_d;
    logic signed [AW-1:0] tgt_ext, acc_step;
    logic [AW-1:0]      step;
    logic               accept, live_off, land;

    assign tgt_ext  = {tgt_i, {FRAC{1'b0}}};
    assign accept   = stb_i && (mode_i != mode_seen_q);
    assign live_off = (rate_sel_e'(rate_sel_i) == RATE_OFF);

    slew_step_lut #(
        .AW(AW), .FRAC(FRAC), .LSB_PER_PPM(LSB_PER_PPM), .TICKS_PER_S(TICKS_PER_S)
    ) u_lut (
        .rate_i (rate_q),
        .step_o (step)
    );

    slew_stepper #(.AW(AW)) u_step (
        .acc_i  (acc_q),
        .tgt_i  (tgt_ext),
        .step_i (step),
        .acc_o  (acc_step),
        .land_o (land)
    );

    // Transitions: TRACK->RAMP (start), RAMP->RAMP (retarget),
    // RAMP->TRACK (land, or unlimited retarget).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: begin
                if (accept && !live_off) state_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (accept) begin
                    state_d = live_off ? ST_TRACK : ST_RAMP;
                end else if (tick_i && land) begin
                    state_d = ST_TRACK;
                end
            end
        endcase
    end

    always_comb begin
        acc_d       = acc_q;
        rate_d      = rate_q;
        mode_seen_d = mode_seen_q;
        if (accept) begin
            rate_d      = rate_sel_e'(rate_sel_i);
            mode_seen_d = mode_i;
        end
        unique case (state_q)
            ST_TRACK: begin
                if (!(accept && !live_off)) acc_d = tgt_ext;
            end
            ST_RAMP: begin
                if (accept) begin
                    if (live_off) acc_d = tgt_ext;
                end else if (tick_i) begin
                    acc_d = acc_step;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q       <= '0;
            rate_q      <= RATE_OFF;
            mode_seen_q <= 1'b0;
        end else begin
            acc_q       <= acc_d;
            rate_q      <= rate_d;
            mode_seen_q <= mode_seen_d;
        end
    end

    // Outputs
    always_comb begin
        out_o     = acc_q[AW-1:FRAC];
        ramping_o = (state_q == ST_RAMP);
    end

endmodule

// File: rtl/freq_slew_pair.sv
module freq_slew_pair #(
    parameter int NCH         = 2,
    parameter int W           = 24,
    parameter int FRAC        = 16,
    parameter int LSB_PER_PPM = 1024,
    parameter int TICKS_PER_S = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic [NCH-1:0]         mode_i,
    input  logic [NCH-1:0]         xfer_stb_i,
    input  logic [NCH-1:0][1:0]    rate_sel_i,
    input  logic [NCH-1:0][W-1:0]  tgt_i,
    output logic [NCH-1:0][W-1:0]  out_o,
    output logic [NCH-1:0]         ramping_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        slew_channel #(
            .W(W), .FRAC(FRAC), .LSB_PER_PPM(LSB_PER_PPM), .TICKS_PER_S(TICKS_PER_S)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_i),
            .mode_i     (mode_i[g]),
            .stb_i      (xfer_stb_i[g]),
            .rate_sel_i (rate_sel_i[g]),
            .tgt_i      (tgt_i[g]),
            .out_o      (out_o[g]),
            .ramping_o  (ramping_o[g])
        );
    end

endmodule

// File: rtl/slew_pair_chk.sv
module slew_pair_chk #(
    parameter int NCH         = 2,
    parameter int W           = 24,
    parameter int LSB_PER_PPM = 1024,
    parameter int TICKS_PER_S = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic [NCH-1:0][1:0]    rate_sel_i,
    input  logic [NCH-1:0][W-1:0]  tgt_i,
    input  logic [NCH-1:0][W-1:0]  out_o,
    input  logic [NCH-1:0]         ramping_o
);

    localparam int MAXJ = (2 * LSB_PER_PPM) / TICKS_PER_S + 2;

    logic armed;
    logic tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            armed  <= 1'b1;
            tick_q <= tick_i;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic signed [W-1:0] o, t, o_q, t_q;
        logic                r_q;
        logic signed [W:0]   dlt;
        logic [W:0]          adlt;

        assign o    = out_o[g];
        assign t    = tgt_i[g];
        assign dlt  = {o[W-1], o} - {o_q[W-1], o_q};
        assign adlt = dlt[W] ? (~dlt + 1'b1) : dlt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                o_q <= '0;
                t_q <= '0;
                r_q <= 1'b0;
            end else begin
                o_q <= o;
                t_q <= t;
                r_q <= ramping_o[g];
            end
        end

        p_track_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !r_q && !ramping_o[g]) |-> (o == t_q));

        p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && r_q && ramping_o[g]) |-> (adlt <= (W+1)'(MAXJ)));

        p_hold_off_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && r_q && ramping_o[g] && !tick_q) |-> (o == o_q));

        p_land_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && r_q && !ramping_o[g]) |-> (o == t_q));

        p_no_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !r_q && ramping_o[g]) |-> (o == o_q));

        p_off_no_ramp_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ramping_o[g] && rate_sel_i[g] == 2'b00) |=> !ramping_o[g]);

        p_toward_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && r_q && ramping_o[g] && tick_q && (t_q > o_q)) |-> (o >= o_q));

        p_toward_dn_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && r_q && ramping_o[g] && tick_q && (t_q < o_q)) |-> (o <= o_q));
    end

endmodule

bind freq_slew_pair slew_pair_chk #(
    .NCH(NCH), .W(W), .LSB_PER_PPM(LSB_PER_PPM), .TICKS_PER_S(TICKS_PER_S)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .rate_sel_i (rate_sel_i),
    .tgt_i      (tgt_i),
    .out_o      (out_o),
    .ramping_o  (ramping_o)
);

// File: tb/sim_freq_slew_pair.sv
module sim_freq_slew_pair;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [1:0]       mode = '0;
    logic [1:0]       stb = '0;
    logic [1:0][1:0]  rate = '0;
    logic [1:0][23:0] tgt = '0;
    logic [1:0][23:0] out;
    logic [1:0]       ramping;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    freq_slew_pair u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .mode_i     (mode),
        .xfer_stb_i (stb),
        .rate_sel_i (rate),
        .tgt_i      (tgt),
        .out_o      (out),
        .ramping_o  (ramping)
    );

    typedef struct packed {
        logic [1:0] r;
        int         a;
        int         b;
        int         n;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 0, 1000, 100},
        '{2'd2, 500, -300, 50},
        '{2'd3, -2000, 2000, 500},
        '{2'd3, 10, 14, 3},
        '{2'd1, 100, 101, 1},
        '{2'd1, 100, 102, 1},
        '{2'd0, 7, -7, 0},
        '{2'd2, -8000000, 8000000, 1000},
        '{2'd1, 0, -1, 1},
        '{2'd3, 300, 0, 40}
    };

    function automatic longint step_of(input int r);
        if (r == 0) return 0;
        return (longint'(r + 1) * 512 * 65536 + 500) / 1000;
    endfunction

    function automatic longint model_acc(input longint a_acc, input longint b,
                                         input int r, input int n);
        longint bx, d, mag, s;
        bx  = b * 65536;
        s   = step_of(r);
        d   = bx - a_acc;
        mag = (d < 0) ? -d : d;
        if (s == 0 || longint'(n) * s >= mag) return bx;
        return (d < 0) ? a_acc - longint'(n) * s : a_acc + longint'(n) * s;
    endfunction

    function automatic bit model_ramp(input longint a_acc, input longint b,
                                      input int r, input int n);
        longint d, mag;
        d   = b * 65536 - a_acc;
        mag = (d < 0) ? -d : d;
        return (r != 0) && (longint'(n) * step_of(r) < mag);
    endfunction

    function automatic longint getout(input int ch);
        return longint'($signed(out[ch]));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; stb = '0; mode = '0; rate = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input int ch, input logic m, input logic [1:0] r, input int t);
        mode[ch] = m; rate[ch] = r; tgt[ch] = 24'(t); stb[ch] = 1'b1;
        @(negedge clk);
        stb[ch] = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        longint acc, a0;
        // R1: reset state with non-zero targets applied
        tgt[0] = 24'd1234; tgt[1] = 24'd777;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 out0", getout(0), 0);
        check("R1 out1", getout(1), 0);
        check("R1 ramping", longint'(ramping), 0);

        // Vector table: R2 tracking, R4 step sizes, R3 ramp, R5 landing, R6 start, R9 off
        for (int i = 0; i < NV; i++) begin
            do_reset();
            tgt[0] = 24'(VEC[i].a);
            repeat (2) @(negedge clk);
            check("R2 track", getout(0), VEC[i].a);
            a0 = longint'(VEC[i].a) * 65536;
            strobe(0, 1'b1, VEC[i].r, VEC[i].b);
            acc = model_acc(a0, VEC[i].b, int'(VEC[i].r), 0);
            check("R6 start", getout(0), acc >>> 16);
            check("R9 start flag", longint'(ramping[0]),
                  longint'(model_ramp(a0, VEC[i].b, int'(VEC[i].r), 0)));
            ticks(VEC[i].n);
            acc = model_acc(a0, VEC[i].b, int'(VEC[i].r), VEC[i].n);
            check(model_ramp(a0, VEC[i].b, int'(VEC[i].r), VEC[i].n) ? "R4 R3 step" : "R5 land",
                  getout(0), acc >>> 16);
            check("R5 flag", longint'(ramping[0]),
                  longint'(model_ramp(a0, VEC[i].b, int'(VEC[i].r), VEC[i].n)));
        end

        // R7: strobe with unchanged mode is ignored
        do_reset();
        tgt[0] = 24'd50;
        repeat (2) @(negedge clk);
        strobe(0, 1'b0, 2'b11, 900);
        check("R7 no ramp", longint'(ramping[0]), 0);
        check("R7 follows", getout(0), 900);

        // R8: rate captured at strobe
        do_reset();
        tgt[0] = '0;
        repeat (2) @(negedge clk);
        strobe(0, 1'b1, 2'b01, 4000);
        rate[0] = 2'b11;
        ticks(40);
        acc = model_acc(0, 4000, 1, 40);
        check("R8 latched rate", getout(0), acc >>> 16);

        // R6: retarget mid-ramp, no jump
        a0 = acc;
        strobe(0, 1'b0, 2'b11, -100);
        check("R6 retarget hold", getout(0), a0 >>> 16);
        check("R6 still ramping", longint'(ramping[0]), 1);
        // R3: no change without ticks
        repeat (5) @(negedge clk);
        check("R3 hold no tick", getout(0), a0 >>> 16);
        ticks(10);
        acc = model_acc(a0, -100, 3, 10);
        check("R6 retarget ramp", getout(0), acc >>> 16);

        // R9: unlimited retarget ends ramp
        strobe(0, 1'b1, 2'b00, 333);
        check("R9 flag", longint'(ramping[0]), 0);
        check("R9 follows", getout(0), 333);

        // R10: channel independence
        do_reset();
        tgt = '0;
        repeat (2) @(negedge clk);
        strobe(1, 1'b1, 2'b10, 5000);
        tgt[0] = 24'd77;
        ticks(20);
        check("R10 ch0 track", getout(0), 77);
        check("R10 ch0 flag", longint'(ramping[0]), 0);
        acc = model_acc(0, 5000, 2, 20);
        check("R10 ch1 ramp", getout(1), acc >>> 16);
        strobe(0, 1'b1, 2'b11, -500);
        check("R10 ch1 unaffected", getout(1), acc >>> 16);
        check("R10 ch1 flag", longint'(ramping[1]), 1);
        check("R10 ch0 ramping", longint'(ramping[0]), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule